// File: doc/BRIEF.md
# Packed FMA Operand Router and Masker

This block wraps a bank of eight double-precision fused multiply-add lanes. It does none of the arithmetic itself. For each 64-bit lane it takes the three packed source vectors and the operand-order code, and from them it presents a multiplicand, a multiplier and an addend. When the third source came from memory it can replace every lane of that source with one 64-bit scalar. It also picks the rounding mode that all lanes use. These operand and rounding outputs are purely combinational, so the lane bank sees them in the same cycle as the instruction fields.

When the lane bank returns its results, the block samples them on the results-valid strobe. It builds the new 512-bit destination from those results. A lane whose write-mask bit is clear either keeps its old value or is cleared, depending on the masking style, and every lane above the active vector length is forced to zero. The destination is registered and appears one cycle after the strobe with a one-cycle valid pulse. An illegal field combination raises an error pulse instead and does not touch the destination. A legacy mode turns off write masking, broadcast and per-instruction rounding, and allows only the two shorter lengths.

Top module: `fma_route_top`

## Requirements
- R1: With order code 00, each lane's multiplicand is the destination/first-source lane, its multiplier is the third-source lane and its addend is the second-source lane.
- R2: With order code 01, the multiplicand is the second source, the multiplier is the destination/first source and the addend is the third source, lane by lane.
- R3: With order code 10, the multiplicand is the second source, the multiplier is the third source and the addend is the destination/first source, lane by lane.
- R4: Outside legacy mode, when `src3Mem` and `bcastBit` are both 1, the operand that would come from the third source takes bits [63:0] of `src3` in every lane. Operands are routed on all eight lanes whatever the length.
- R5: `laneRound` equals `instrRound` only when the mode is not legacy, `src3Mem` is 0, `lenCode` is 10 (512 bits) and `bcastBit` is 1. In every other case it equals `globalRound`. The codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero.
- R6: `lenCode` 00, 01 and 10 select 2, 4 and 8 active lanes. Lane j is bits [64j+63:64j]. Every destination bit at or above the active length is 0 after a legal operation, whatever the mask.
- R7: An active lane takes its `laneRes` slice when its `laneMask` bit is 1. When `maskEn` is 0, every active lane takes its result.
- R8: With `maskEn` 1, an active lane whose mask bit is 0 keeps the old value of its `srcDest` lane when `zeroMask` is 0, and becomes 0 when `zeroMask` is 1.
- R9: In legacy mode (`legacyMode`=1), `laneMask`, `maskEn`, `zeroMask` and `bcastBit` have no effect, and rounding always comes from `globalRound`.
- R10: The destination is captured only in a cycle with `resValid` high. `destOut` takes the merged value at the next clock edge, and `destValid` is high for exactly that one cycle per strobe.
- R11: Order code 11, length code 11, or length 10 in legacy mode, when sampled with `resValid`, raises `errFlag` for one cycle, keeps `destValid` low and leaves `destOut` unchanged.
- R12: After reset, `destOut` is zero and `destValid` and `errFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| order | input | 2 | Operand-order code (00, 01, 10; 11 illegal) |
| lenCode | input | 2 | Vector length code (00=128, 01=256, 10=512; 11 illegal) |
| legacyMode | input | 1 | Legacy encoding: no mask, no broadcast, no rounding override |
| maskEn | input | 1 | Write mask in use |
| zeroMask | input | 1 | 1 = zero masked lanes, 0 = merge |
| laneMask | input | 8 | Per-lane write mask |
| src3Mem | input | 1 | Third source is a memory operand |
| bcastBit | input | 1 | Broadcast / embedded-rounding control bit |
| instrRound | input | 2 | Per-instruction rounding code |
| globalRound | input | 2 | Rounding code from the global control register |
| srcDest | input | 512 | Destination and first source (old value) |
| src2 | input | 512 | Second source |
| src3 | input | 512 | Third source |
| laneA | output | 512 | Per-lane multiplicand |
| laneB | output | 512 | Per-lane multiplier |
| laneC | output | 512 | Per-lane addend |
| laneRound | output | 2 | Rounding code sent to all lanes |
| resValid | input | 1 | Lane results valid, capture strobe |
| laneRes | input | 512 | Rounded lane results |
| destOut | output | 512 | Registered merged destination |
| destValid | output | 1 | One-cycle pulse with a new destination |
| errFlag | output | 1 | One-cycle pulse on an illegal combination |

## Verification
Masking and length clearing act in the same capture. A lane can have its mask bit set, or be under merge masking with the bit clear, and still lie above the active length. In that case the length rule must win and the lane must read zero. The bench provokes this with short lengths, all-ones destinations and both full and empty masks. The broadcast bit also serves two roles in one cycle: it is broadcast for a memory source and a rounding override for a register source at 512 bits. Both cases are driven with distinct `instrRound` and `globalRound` codes. A behavioural reference model checks every cycle, comparing the routed operands, the rounding code and the registered destination.

// File: rtl/fma_route_pkg.sv
package fma_route_pkg;
  localparam int LANES       = 8;
  localparam int LANE_W      = 64;
  localparam int VEC_W       = LANES * LANE_W;
  localparam int VL_MIN_BITS = 128;
  localparam int MIN_LANES   = VL_MIN_BITS / LANE_W;
  localparam int CNT_W       = $clog2(LANES) + 2;

  localparam logic [1:0] ORD_132 = 2'b00;
  localparam logic [1:0] ORD_213 = 2'b01;
  localparam logic [1:0] ORD_231 = 2'b10;
  localparam logic [1:0] ORD_BAD = 2'b11;

  localparam logic [1:0] LEN_128 = 2'b00;
  localparam logic [1:0] LEN_256 = 2'b01;
  localparam logic [1:0] LEN_512 = 2'b10;
  localparam logic [1:0] LEN_BAD = 2'b11;

  typedef struct packed {
    logic             commit;
    logic             fault;
    logic             bcast;
    logic [1:0]       order;
    logic [1:0]       rnd;
    logic [LANES-1:0] active;
    logic [LANES-1:0] takeRes;
    logic [LANES-1:0] keepOld;
  } strobe_t;
endpackage

// File: rtl/fma_route_ctrl.sv
module fma_route_ctrl
  import fma_route_pkg::*;
(
  input  logic [1:0]       order,
  input  logic [1:0]       lenCode,
  input  logic             legacyMode,
  input  logic             maskEn,
  input  logic             zeroMask,
  input  logic [LANES-1:0] laneMask,
  input  logic             src3Mem,
  input  logic             bcastBit,
  input  logic [1:0]       instrRound,
  input  logic [1:0]       globalRound,
  input  logic             resValid,
  output strobe_t          strb
);
  logic orderOk;
  logic lenOk;
  logic legal;
  logic override;
  logic [CNT_W-1:0] laneCnt;
  logic [LANES-1:0] activeV;
  logic [LANES-1:0] writeV;

  always_comb begin
    orderOk  = (order != ORD_BAD);
    lenOk    = (lenCode != LEN_BAD) && !(legacyMode && lenCode == LEN_512);
    legal    = orderOk && lenOk;
    override = !legacyMode && !src3Mem && bcastBit && (lenCode == LEN_512);
  end

  always_comb begin
    case (lenCode)
      LEN_128: laneCnt = CNT_W'(MIN_LANES);
      LEN_256: laneCnt = CNT_W'(MIN_LANES * 2);
      LEN_512: laneCnt = CNT_W'(MIN_LANES * 4);
      default: laneCnt = '0;
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_act
    assign activeV[j] = (laneCnt > CNT_W'(j));
  end

  assign writeV = (legacyMode || !maskEn) ? {LANES{1'b1}} : laneMask;

  always_comb begin
    strb.commit  = resValid && legal;
    strb.fault   = resValid && !legal;
    strb.bcast   = !legacyMode && src3Mem && bcastBit;
    strb.order   = order;
    strb.rnd     = override ? instrRound : globalRound;
    strb.active  = activeV;
    strb.takeRes = activeV & writeV;
    strb.keepOld = (legacyMode || zeroMask) ? '0 : (activeV & ~writeV);
  end
endmodule

// File: rtl/fma_route_dp.sv
module fma_route_dp
  import fma_route_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [VEC_W-1:0] srcDest,
  input  logic [VEC_W-1:0] src2,
  input  logic [VEC_W-1:0] src3,
  input  logic [VEC_W-1:0] laneRes,
  output logic [VEC_W-1:0] laneA,
  output logic [VEC_W-1:0] laneB,
  output logic [VEC_W-1:0] laneC,
  output logic [VEC_W-1:0] destOut,
  output logic             destValid,
  output logic             errFlag
);
  logic [VEC_W-1:0] merged;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] dLane;
    logic [LANE_W-1:0] s2Lane;
    logic [LANE_W-1:0] s3Lane;
    logic [LANE_W-1:0] rLane;

    assign dLane  = srcDest[j*LANE_W +: LANE_W];
    assign s2Lane = src2[j*LANE_W +: LANE_W];
    assign s3Lane = strb.bcast ? src3[LANE_W-1:0] : src3[j*LANE_W +: LANE_W];
    assign rLane  = laneRes[j*LANE_W +: LANE_W];

    always_comb begin
      case (strb.order)
        ORD_213: begin
          laneA[j*LANE_W +: LANE_W] = s2Lane;
          laneB[j*LANE_W +: LANE_W] = dLane;
          laneC[j*LANE_W +: LANE_W] = s3Lane;
        end
        ORD_231: begin
          laneA[j*LANE_W +: LANE_W] = s2Lane;
          laneB[j*LANE_W +: LANE_W] = s3Lane;
          laneC[j*LANE_W +: LANE_W] = dLane;
        end
        default: begin
          laneA[j*LANE_W +: LANE_W] = dLane;
          laneB[j*LANE_W +: LANE_W] = s3Lane;
          laneC[j*LANE_W +: LANE_W] = s2Lane;
        end
      endcase
    end

    always_comb begin
      if (strb.takeRes[j])      merged[j*LANE_W +: LANE_W] = rLane;
      else if (strb.keepOld[j]) merged[j*LANE_W +: LANE_W] = dLane;
      else                      merged[j*LANE_W +: LANE_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destOut   <= '0;
      destValid <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      destValid <= strb.commit;
      errFlag   <= strb.fault;
      if (strb.commit) destOut <= merged;
    end
  end
endmodule

// File: rtl/fma_route_top.sv
module fma_route_top
  import fma_route_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       order,
  input  logic [1:0]       lenCode,
  input  logic             legacyMode,
  input  logic             maskEn,
  input  logic             zeroMask,
  input  logic [LANES-1:0] laneMask,
  input  logic             src3Mem,
  input  logic             bcastBit,
  input  logic [1:0]       instrRound,
  input  logic [1:0]       globalRound,
  input  logic [VEC_W-1:0] srcDest,
  input  logic [VEC_W-1:0] src2,
  input  logic [VEC_W-1:0] src3,
  output logic [VEC_W-1:0] laneA,
  output logic [VEC_W-1:0] laneB,
  output logic [VEC_W-1:0] laneC,
  output logic [1:0]       laneRound,
  input  logic             resValid,
  input  logic [VEC_W-1:0] laneRes,
  output logic [VEC_W-1:0] destOut,
  output logic             destValid,
  output logic             errFlag
);
  strobe_t strb;

  fma_route_ctrl u_ctrl (
    .order(order), .lenCode(lenCode), .legacyMode(legacyMode),
    .maskEn(maskEn), .zeroMask(zeroMask), .laneMask(laneMask),
    .src3Mem(src3Mem), .bcastBit(bcastBit), .instrRound(instrRound),
    .globalRound(globalRound), .resValid(resValid), .strb(strb)
  );

  fma_route_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcDest(srcDest), .src2(src2),
    .src3(src3), .laneRes(laneRes), .laneA(laneA), .laneB(laneB),
    .laneC(laneC), .destOut(destOut), .destValid(destValid), .errFlag(errFlag)
  );

  assign laneRound = strb.rnd;
endmodule

// File: rtl/fma_route_chk.sv
module fma_route_chk
  import fma_route_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       order,
  input logic [1:0]       lenCode,
  input logic             legacyMode,
  input logic             src3Mem,
  input logic             bcastBit,
  input logic [1:0]       globalRound,
  input logic [VEC_W-1:0] src3,
  input logic [VEC_W-1:0] laneB,
  input logic [1:0]       laneRound,
  input logic             resValid,
  input logic [VEC_W-1:0] destOut,
  input logic             destValid,
  input logic             errFlag
);
  logic fieldsOk;
  assign fieldsOk = (order != 2'b11) && (lenCode != 2'b11) &&
                    !(legacyMode && lenCode == 2'b10);

  AST_VALID_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && fieldsOk) |=> destValid); // R10
  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    destValid |-> $past(resValid)); // R10
  AST_ERR_KEEPS_DEST: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $stable(destOut)); // R11
  AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(errFlag && destValid)); // R11
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (destValid && $past(lenCode) == 2'b00) |-> (destOut[VEC_W-1:128] == '0)); // R6
  AST_LEGACY_ROUND: assert property (@(posedge clk) disable iff (!rstN)
    legacyMode |-> (laneRound == globalRound)); // R9
  AST_BCAST_LANE1: assert property (@(posedge clk) disable iff (!rstN)
    (!legacyMode && src3Mem && bcastBit && order == 2'b00)
      |-> (laneB[2*LANE_W-1:LANE_W] == src3[LANE_W-1:0])); // R4
endmodule

bind fma_route_top fma_route_chk u_chk (
  .clk(clk), .rstN(rstN), .order(order), .lenCode(lenCode),
  .legacyMode(legacyMode), .src3Mem(src3Mem), .bcastBit(bcastBit),
  .globalRound(globalRound), .src3(src3), .laneB(laneB),
  .laneRound(laneRound), .resValid(resValid), .destOut(destOut),
  .destValid(destValid), .errFlag(errFlag)
);

// File: tb/tb_fma_route_top.sv
module tb_fma_route_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic [1:0] order, lenCode, instrRound, globalRound;
  logic legacyMode, maskEn, zeroMask, src3Mem, bcastBit, resValid;
  logic [7:0] laneMask;
  logic [511:0] srcDest, src2, src3, laneRes;
  logic [511:0] laneA, laneB, laneC, destOut;
  logic [1:0] laneRound;
  logic destValid, errFlag;

  int checks = 0;
  int fails = 0;
  string curTag = "R10";
  logic [511:0] expDest = '0;
  logic expValid = 1'b0;
  logic expErr = 1'b0;

  fma_route_top dut (.*);

  task automatic chk(input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pick(input logic [511:0] v, input int j);
    return v[64*j +: 64];
  endfunction

  task automatic checkComb();
    logic [511:0] ea, eb, ec;
    logic [63:0] t3;
    logic [1:0] er;
    string tg;
    bit bc;
    bc = !legacyMode && src3Mem && bcastBit;
    tg = bc ? "R4" : (order == 2'b00 ? "R1" : (order == 2'b01 ? "R2" : "R3"));
    if (order != 2'b11) begin
      for (int j = 0; j < 8; j++) begin
        t3 = bc ? src3[63:0] : pick(src3, j);
        if (order == 2'b00) begin
          ea[64*j +: 64] = pick(srcDest, j); eb[64*j +: 64] = t3; ec[64*j +: 64] = pick(src2, j);
        end else if (order == 2'b01) begin
          ea[64*j +: 64] = pick(src2, j); eb[64*j +: 64] = pick(srcDest, j); ec[64*j +: 64] = t3;
        end else begin
          ea[64*j +: 64] = pick(src2, j); eb[64*j +: 64] = t3; ec[64*j +: 64] = pick(srcDest, j);
        end
      end
      chk(tg, "laneA", laneA, ea);
      chk(tg, "laneB", laneB, eb);
      chk(tg, "laneC", laneC, ec);
    end
    er = (!legacyMode && !src3Mem && lenCode == 2'b10 && bcastBit) ? instrRound : globalRound;
    chk(legacyMode ? "R9" : "R5", "laneRound", {510'd0, laneRound}, {510'd0, er});
  endtask

  task automatic modelEdge();
    int n;
    bit ok;
    if (!rstN) begin
      expDest = '0; expValid = 0; expErr = 0;
    end else if (!resValid) begin
      expValid = 0; expErr = 0;
    end else begin
      ok = (order != 2'b11) && (lenCode != 2'b11) && !(legacyMode && lenCode == 2'b10);
      if (!ok) begin
        expValid = 0; expErr = 1;
      end else begin
        expValid = 1; expErr = 0;
        n = (lenCode == 2'b00) ? 2 : (lenCode == 2'b01) ? 4 : 8;
        for (int j = 0; j < 8; j++) begin
          if (j >= n) expDest[64*j +: 64] = '0;
          else if (legacyMode || !maskEn || laneMask[j]) expDest[64*j +: 64] = pick(laneRes, j);
          else if (zeroMask) expDest[64*j +: 64] = '0;
          else expDest[64*j +: 64] = pick(srcDest, j);
        end
      end
    end
  endtask

  task automatic cycle();
    #1;
    checkComb();
    modelEdge();
    @(posedge clk);
    #1;
    chk(curTag, "destOut", destOut, expDest);
    chk("R10", "destValid", {511'd0, destValid}, {511'd0, expValid});
    chk("R11", "errFlag", {511'd0, errFlag}, {511'd0, expErr});
    @(negedge clk);
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic setOp(input logic [1:0] o, input logic [1:0] l, input logic leg,
                       input logic me, input logic zm, input logic [7:0] m,
                       input logic mem, input logic bc);
    order = o; lenCode = l; legacyMode = leg; maskEn = me; zeroMask = zm;
    laneMask = m; src3Mem = mem; bcastBit = bc; resValid = 1'b1;
    srcDest = rnd512(); src2 = rnd512(); src3 = rnd512(); laneRes = rnd512();
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; order = 0; lenCode = 2; legacyMode = 0; maskEn = 0; zeroMask = 0;
    laneMask = 0; src3Mem = 0; bcastBit = 0; instrRound = 2'b11; globalRound = 2'b01;
    resValid = 0; srcDest = '0; src2 = '0; src3 = '0; laneRes = '0;
    @(negedge clk);
    curTag = "R12"; cycle(); cycle();
    rstN = 1;

    curTag = "R1"; setOp(2'b00, 2'b10, 0, 0, 0, 8'h00, 0, 0); cycle();
    curTag = "R2"; setOp(2'b01, 2'b10, 0, 0, 0, 8'h00, 0, 0); cycle();
    curTag = "R3"; setOp(2'b10, 2'b10, 0, 0, 0, 8'h00, 0, 0); cycle();
    curTag = "R4"; setOp(2'b00, 2'b10, 0, 0, 0, 8'h00, 1, 1); cycle();
    setOp(2'b10, 2'b01, 0, 0, 0, 8'h00, 1, 1); cycle();
    setOp(2'b01, 2'b00, 0, 0, 0, 8'h00, 1, 1); cycle();
    curTag = "R5"; setOp(2'b00, 2'b10, 0, 0, 0, 8'h00, 0, 1); cycle();
    setOp(2'b00, 2'b01, 0, 0, 0, 8'h00, 0, 1); cycle();
    instrRound = 2'b10; globalRound = 2'b00;
    setOp(2'b01, 2'b10, 0, 0, 0, 8'h00, 0, 1); cycle();
    curTag = "R6"; setOp(2'b00, 2'b00, 0, 0, 0, 8'h00, 0, 0); cycle();
    setOp(2'b00, 2'b01, 0, 1, 0, 8'hFF, 0, 0); srcDest = '1; cycle();
    setOp(2'b01, 2'b00, 0, 1, 0, 8'h00, 0, 0); srcDest = '1; cycle();
    curTag = "R7"; setOp(2'b10, 2'b10, 0, 1, 0, 8'hA5, 0, 0); cycle();
    setOp(2'b10, 2'b10, 0, 0, 1, 8'h00, 0, 0); cycle();
    curTag = "R8"; setOp(2'b00, 2'b10, 0, 1, 0, 8'h3C, 0, 0); cycle();
    setOp(2'b00, 2'b10, 0, 1, 1, 8'h3C, 0, 0); cycle();
    setOp(2'b01, 2'b01, 0, 1, 1, 8'hF6, 0, 0); cycle();
    curTag = "R9"; setOp(2'b00, 2'b01, 1, 1, 1, 8'h00, 1, 1); cycle();
    setOp(2'b10, 2'b00, 1, 1, 0, 8'h01, 0, 1); cycle();
    curTag = "R11"; setOp(2'b11, 2'b10, 0, 0, 0, 8'h00, 0, 0); cycle();
    setOp(2'b00, 2'b11, 0, 0, 0, 8'h00, 0, 0); cycle();
    setOp(2'b01, 2'b10, 1, 0, 0, 8'h00, 0, 0); cycle();
    curTag = "R10"; setOp(2'b00, 2'b10, 0, 0, 0, 8'h00, 0, 0); resValid = 0; cycle();
    setOp(2'b01, 2'b01, 0, 0, 0, 8'h00, 0, 0); cycle();
    setOp(2'b10, 2'b10, 0, 1, 0, 8'h0F, 1, 0); cycle();

    for (int i = 0; i < 400; i++) begin
      setOp(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 1'($urandom),
            1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
      resValid = ($urandom_range(0, 3) != 0);
      instrRound = 2'($urandom); globalRound = 2'($urandom);
      cycle();
    end

    resValid = 0;
    cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule